// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block drives the four gates of a single H-bridge and holds the load current near a limit set by an external comparator. It has no duty-cycle generator. The bridge conducts on the diagonal chosen by the direction input until the comparator reports that the sensed current is above the reference. At that point the low-side switch that is conducting turns off for a fixed number of clock cycles. During that interval the high-side switch on the same leg turns on, so the current recirculates through the two upper switches (slow decay with synchronous rectification). When the interval ends, the block returns to the commanded diagonal.

Every timing interval is a count of clock cycles, set by a parameter. The intervals are: the one-shot off time, the dead time inserted whenever one switch of a leg hands over to the other, a blanking window at the start of each on phase that hides the recovery spike, and a minimum on time. A comparator assertion that arrives too early is held until both the blanking window and the minimum on time have closed, and acts then only if the comparator is still high. Dropping the enable input turns every gate off at once and resets every timer.

Top module: `chop_ctrl`

## Requirements
- R1: While rst_n is low or en is low, all four gate outputs are 0, and they fall in the same cycle en falls, with no clock edge needed.
- R2: In the on phase, dir=0 drives a_hi=1 and b_lo=1, and dir=1 drives b_hi=1 and a_lo=1. The other two gates are 0, and the two low-side gates are never 1 together.
- R3: When the comparator trips, the conducting low-side gate turns off at the next clock edge. The source high-side gate (a_hi for dir=0, b_hi for dir=1) stays on through the whole off phase. The high side of the sink leg is on for OFF_CYC-DEAD_CYC cycles, starting DEAD_CYC cycles after the trip.
- R4: After a trip, the low-side gate stays off for exactly OFF_CYC+DEAD_CYC cycles: the one-shot plus a closing dead time. It then turns back on.
- R5: The comparator is ignored during the first BLANK_CYC cycles of every on phase. A pulse that is confined to that window causes no trip.
- R6: An on phase lasts at least MINON_CYC cycles. A comparator that is held high from the start of an on phase trips exactly when the later of the blanking window and the minimum on time closes, so the on phase lasts max(BLANK_CYC, MINON_CYC-1)+1 cycles.
- R7: No leg has its high and low gates on in the same cycle. Within a leg, each handover between the two gates passes through at least one cycle with both off, and the recirculation high side waits DEAD_CYC cycles after its low side turns off.
- R8: A change of dir while enabled turns all four gates off for exactly DEAD_CYC cycles. The block then enters the on phase of the new diagonal with blanking active.
- R9: On re-enable, the block starts in the on phase of the current diagonal with its timers cleared. An off phase that was cut short by a disable is not resumed, and blanking and the minimum on time apply again.
- R10: While the comparator stays low, the on phase continues with no limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bridge enable; low forces all gates off |
| dir | input | 1 | Diagonal select: 0 = A high to B low, 1 = B high to A low |
| cmp_hi | input | 1 | Synchronous comparator flag, high when the sensed current exceeds the reference |
| a_hi | output | 1 | Leg A high-side gate |
| a_lo | output | 1 | Leg A low-side gate |
| b_hi | output | 1 | Leg B high-side gate |
| b_lo | output | 1 | Leg B low-side gate |

## Verification
Several properties are checked on every cycle. The gates of a leg are mutually exclusive, the two low sides are never on together, and every handover within a leg leaves at least one cycle with both gates off. A disabled bridge is fully off. Each chopped on phase lasts at least the minimum on time, and each chopped off interval on the low side is exactly the one-shot plus dead time long. Other behaviours need chosen stimulus, so only the directed scenarios can show them: comparator pulses confined to the blanking window are ignored, an early comparator assertion takes effect exactly when the window closes, recirculation begins after one dead time, an all-off gap appears on a direction change, and timers restart when the bridge is re-enabled during an off phase.

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int unsigned OFF_CYC   = 1000,
  parameter int unsigned DEAD_CYC  = 125,
  parameter int unsigned BLANK_CYC = 125,
  parameter int unsigned MINON_CYC = 313
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dir,
  input  logic cmp_hi,
  output logic a_hi,
  output logic a_lo,
  output logic b_hi,
  output logic b_lo
);
  localparam int unsigned WIN  = (BLANK_CYC > MINON_CYC - 1) ? BLANK_CYC : MINON_CYC - 1;
  localparam int unsigned CM1  = (OFF_CYC > DEAD_CYC) ? OFF_CYC : DEAD_CYC;
  localparam int unsigned CMAX = (CM1 > WIN) ? CM1 : WIN;
  localparam int          CW   = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_ON, S_OFF, S_RESUME, S_SWAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          dir_q;

  wire live      = en & rst_n;
  wire win_open  = (cnt >= CW'(WIN));
  wire off_last  = (cnt == CW'(OFF_CYC - 1));
  wire dead_last = (cnt == CW'(DEAD_CYC - 1));
  wire cnt_inc   = cnt + CW'(1);

  logic [CW-1:0] cnt_nx;
  assign cnt_nx = cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_ON;
      cnt   <= '0;
      dir_q <= 1'b0;
    end else if (!en) begin
      st    <= S_ON;
      cnt   <= '0;
      dir_q <= dir;
    end else if (dir != dir_q) begin
      st    <= S_SWAP;
      cnt   <= '0;
      dir_q <= dir;
    end else begin
      unique case (st)
        S_ON: begin
          if (cmp_hi && win_open) begin
            st  <= S_OFF;
            cnt <= '0;
          end else if (!win_open) begin
            cnt <= cnt_nx;
          end
        end
        S_OFF: begin
          if (off_last) begin
            st  <= S_RESUME;
            cnt <= '0;
          end else begin
            cnt <= cnt_nx;
          end
        end
        S_RESUME, S_SWAP: begin
          if (dead_last) begin
            st  <= S_ON;
            cnt <= '0;
          end else begin
            cnt <= cnt_nx;
          end
        end
        default: begin
          st  <= S_ON;
          cnt <= '0;
        end
      endcase
    end
  end

  wire src_hi  = live && (st != S_SWAP);
  wire sink_lo = live && (st == S_ON);
  wire sink_hi = live && (st == S_OFF) && (cnt >= CW'(DEAD_CYC));

  assign a_hi = dir_q ? sink_hi : src_hi;
  assign b_hi = dir_q ? src_hi  : sink_hi;
  assign a_lo = dir_q & sink_lo;
  assign b_lo = ~dir_q & sink_lo;

  wire unused_ok = cnt_inc;
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk #(
  parameter int unsigned OFF_CYC   = 1000,
  parameter int unsigned DEAD_CYC  = 125,
  parameter int unsigned MINON_CYC = 313
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic a_hi,
  input logic a_lo,
  input logic b_hi,
  input logic b_lo
);
  wire lo_any = a_lo | b_lo;
  wire hi_any = a_hi | b_hi;

  logic [31:0] on_run, off_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_run  <= '0;
      off_run <= '0;
    end else begin
      on_run  <= lo_any ? ((on_run == '1) ? on_run : on_run + 32'd1) : 32'd0;
      off_run <= (!lo_any && hi_any) ? ((off_run == '1) ? off_run : off_run + 32'd1) : 32'd0;
    end
  end

  p_leg_a_excl_r7: assert property (@(posedge clk) disable iff (!rst_n) !(a_hi && a_lo));
  p_leg_b_excl_r7: assert property (@(posedge clk) disable iff (!rst_n) !(b_hi && b_lo));
  p_gap_a_lo_hi_r7: assert property (@(posedge clk) disable iff (!rst_n) $past(a_lo) |-> !a_hi);
  p_gap_a_hi_lo_r7: assert property (@(posedge clk) disable iff (!rst_n) $past(a_hi) |-> !a_lo);
  p_gap_b_lo_hi_r7: assert property (@(posedge clk) disable iff (!rst_n) $past(b_lo) |-> !b_hi);
  p_gap_b_hi_lo_r7: assert property (@(posedge clk) disable iff (!rst_n) $past(b_hi) |-> !b_lo);
  p_one_low_r2: assert property (@(posedge clk) disable iff (!rst_n) !(a_lo && b_lo));
  p_dis_off_r1: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !(hi_any || lo_any));
  p_min_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lo_any) && hi_any) |-> (on_run >= 32'(MINON_CYC)));
  p_off_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lo_any) && $past(hi_any)) |-> (off_run == 32'(OFF_CYC + DEAD_CYC)));
endmodule

bind chop_ctrl chop_ctrl_chk #(
  .OFF_CYC(OFF_CYC), .DEAD_CYC(DEAD_CYC), .MINON_CYC(MINON_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
);

// File: tb/chop_ctrl_tb.sv
`timescale 1ns/1ps
module chop_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic dir = 1'b0;
  logic cmp_hi = 1'b0;
  logic a_hi, a_lo, b_hi, b_lo;
  logic [3:0] outs;
  int checks = 0;
  int errors = 0;

  assign outs = {a_hi, a_lo, b_hi, b_lo};
  always #4 clk = ~clk;

  chop_ctrl #(.OFF_CYC(10), .DEAD_CYC(3), .BLANK_CYC(6), .MINON_CYC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .cmp_hi(cmp_hi),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic span(input int idx, input logic val, output int n);
    n = 0;
    while (outs[idx] == val && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    #20;
    chk("R1 gates off in reset", outs, 0);
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 gates off while disabled", outs, 0);
  endtask

  task automatic t_chop_dir0;
    int n, nlo;
    @(negedge clk);
    en = 1'b1; dir = 1'b0; cmp_hi = 1'b1;
    #1;
    chk("R2 dir0 on-phase gates", outs, 4'b1001);
    span(0, 1'b1, n);
    chk("R6 on length with comparator held high", n, 7);
    chk("R3 sink low off, source high kept", outs, 4'b1000);
    cmp_hi = 1'b0;
    span(1, 1'b0, n);
    chk("R7 dead time before recirculation", n, 3);
    nlo = n;
    chk("R3 source high during recirculation", a_hi, 1);
    span(1, 1'b1, n);
    chk("R3 recirculation high-side length", n, 7);
    nlo += n;
    chk("R7 closing dead time gates", outs, 4'b1000);
    span(0, 1'b0, n);
    nlo += n;
    chk("R4 low-side off span", nlo, 13);
    chk("R2 drive resumed", outs, 4'b1001);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (outs == 4'b1001) n++;
    end
    chk("R10 on phase holds with comparator low", n, 40);
  endtask

  task automatic t_blanking;
    int lows;
    @(negedge clk);
    en = 1'b0;
    #1;
    chk("R1 immediate off on disable", outs, 0);
    @(negedge clk);
    en = 1'b1; cmp_hi = 1'b1;
    #1;
    chk("R9 restart in on phase", outs, 4'b1001);
    repeat (4) @(negedge clk);
    cmp_hi = 1'b0;
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (outs != 4'b1001) lows++;
    end
    chk("R5 comparator pulse inside blanking ignored", lows, 0);
  endtask

  task automatic t_mid_off;
    int n;
    @(negedge clk);
    cmp_hi = 1'b1;
    n = 0;
    while (b_hi != 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R3 recirculation reached", outs, 4'b1010);
    en = 1'b0;
    #1;
    chk("R1 disable mid off phase", outs, 0);
    @(negedge clk);
    en = 1'b1;
    #1;
    chk("R9 re-enable enters on phase", outs, 4'b1001);
    span(0, 1'b1, n);
    chk("R9 timers restarted after re-enable", n, 7);
    cmp_hi = 1'b0;
    n = 0;
    while (b_lo != 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R4 off span after restart", n, 13);
  endtask

  task automatic t_swap;
    int n;
    @(negedge clk);
    dir = 1'b1;
    @(negedge clk);
    n = 0;
    while (outs == 4'b0000 && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R8 all-off gap on direction change", n, 3);
    chk("R8 dir1 on-phase gates", outs, 4'b0110);
    cmp_hi = 1'b1;
    span(2, 1'b1, n);
    chk("R6 dir1 on length with blanking active", n, 7);
    chk("R3 dir1 sink low off, source high kept", outs, 4'b0010);
    cmp_hi = 1'b0;
    span(3, 1'b0, n);
    chk("R7 dir1 dead time before recirculation", n, 3);
    chk("R3 dir1 recirculation both highs", outs, 4'b1010);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_chop_dir0();
    t_blanking();
    t_mid_off();
    t_swap();
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule